// File: doc/BRIEF.md
# Variable-Page Translation CAM with Exclusion Holes

This block is a small, fully associative translation cache that sits in front of a larger translation table. Each lookup presents a virtual page number, which is bits 63:12 of a 64-bit address, 52 bits wide. The block compares that number against every valid entry at the same time. Each comparison ignores the page-number bits that lie inside that entry's page, so 4 KB, 64 KB, 1 MB, 16 MB and 1 GB pages can all be resident together. On a hit the block returns a physical page number. Its upper bits come from the entry and its intra-page bits come from the lookup address.

An entry larger than 4 KB can carry an exclusion window at the bottom of its page. The entry's page-number bits below its page boundary, which the match does not otherwise use, then describe the window size as a run of low-order ones. Addresses inside the window do not match that entry. This lets smaller entries claim pages inside the window while the large entry covers the rest of its span.

A single write port replaces one entry at a time. At reset one boot entry is loaded already valid, so fetches can translate before any entry has been written. Lookup results appear one cycle after the request.

Top module: `xlat_cam`

## Requirements
- R1: Size codes are 001 = 4 KB, 011 = 64 KB, 101 = 1 MB, 111 = 16 MB and 110 = 1 GB. These cover 0, 4, 8, 12 and 18 low page-number bits respectively. Those low bits are left out of the compare, and on a hit they pass from the lookup address straight into the returned physical page number.
- R2: An entry whose valid bit is 0, or whose size code is none of the five legal codes, never hits.
- R3: Let r be the low page-number bits of an entry larger than 4 KB whose exclusion bit is set. A lookup whose intra-page bits have no 1 outside r lies in the exclusion window and does not hit that entry. For a legal r = 2^n − 1, this is the lowest 2^n × 4 KB of the page.
- R4: On a 4 KB entry the exclusion bit has no effect.
- R5: Smaller entries mapped inside another entry's exclusion window hit for their own pages. Window addresses that no entry maps miss, and addresses above the window hit the large entry.
- R6: When more than one entry hits, rsp_multi is 1 and the lowest-index hitting entry supplies rsp_idx and rsp_rpn.
- R7: rsp_valid is 1 exactly one cycle after a cycle with lk_req = 1. rsp_hit is 0 whenever rsp_valid is 0.
- R8: A write is seen by lookups requested in the following cycle and later. A lookup requested in the same cycle as the write sees the old contents.
- R9: After reset, entry ENTRIES−1 holds the boot entry, valid and of 4 KB size, with its page numbers set by parameter (default virtual page all ones, physical page all ones). All other entries are invalid. A miss returns rsp_idx = 0 and rsp_rpn = 0.
- R10: Entries of all five sizes can be resident together and each translates correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 52 | Virtual page number to translate |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IW | Entry index to write |
| wr_valid | input | 1 | Valid bit written |
| wr_excl | input | 1 | Exclusion-window enable written |
| wr_size | input | 3 | Size code written |
| wr_vpn | input | 52 | Virtual page number (with window code) written |
| wr_rpn | input | 40 | Physical page number written |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Some entry matched |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_idx | output | IW | Index of the selected entry |
| rsp_rpn | output | 40 | Translated physical page number |

## Verification
A write and a lookup can land on the same entry in the same cycle. The bench provokes this by writing a new mapping while it looks up that mapping's address in the same cycle, and it expects a miss. It then repeats the lookup one cycle later and expects a hit, and after invalidating the entry it expects a miss again. Window suppression and matches from smaller entries also meet inside one compare. The bench judges them with lookups at the window's bottom and top, at mapped and unmapped pages inside it, and just above it.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 52;
  localparam int RPN_W = 40;

  localparam logic [2:0] SZ_4K  = 3'b001;
  localparam logic [2:0] SZ_64K = 3'b011;
  localparam logic [2:0] SZ_1M  = 3'b101;
  localparam logic [2:0] SZ_16M = 3'b111;
  localparam logic [2:0] SZ_1G  = 3'b110;

  typedef struct packed {
    logic             valid;
    logic             excl;
    logic [2:0]       size;
    logic [VPN_W-1:0] vpn;
    logic [RPN_W-1:0] rpn;
  } xlat_ent_t;

  function automatic logic size_ok(input logic [2:0] s);
    return (s == SZ_4K) || (s == SZ_64K) || (s == SZ_1M) ||
           (s == SZ_16M) || (s == SZ_1G);
  endfunction

  // page-number bits that lie inside the page
  function automatic logic [VPN_W-1:0] offs_mask(input logic [2:0] s);
    case (s)
      SZ_64K:  return VPN_W'(20'h0000F);
      SZ_1M:   return VPN_W'(20'h000FF);
      SZ_16M:  return VPN_W'(20'h00FFF);
      SZ_1G:   return VPN_W'(20'h3FFFF);
      default: return '0;
    endcase
  endfunction

  function automatic logic tag_eq(input xlat_ent_t e, input logic [VPN_W-1:0] va);
    return ((va ^ e.vpn) & ~offs_mask(e.size)) == '0;
  endfunction

  // window = intra-page bits whose ones all lie inside the stored code
  function automatic logic in_hole(input xlat_ent_t e, input logic [VPN_W-1:0] va);
    return e.excl && (e.size != SZ_4K) && size_ok(e.size) &&
           ((va & offs_mask(e.size) & ~e.vpn) == '0);
  endfunction

  function automatic logic [RPN_W-1:0] rpn_out(input xlat_ent_t e,
                                               input logic [VPN_W-1:0] va);
    logic [RPN_W-1:0] m;
    m = offs_mask(e.size)[RPN_W-1:0];
    return (e.rpn & ~m) | (va[RPN_W-1:0] & m);
  endfunction
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
  import xlat_pkg::*;
#(
  parameter bit        IS_BOOT  = 1'b0,
  parameter xlat_ent_t BOOT_ENT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  xlat_ent_t        wr_ent,
  input  logic [VPN_W-1:0] lk_vpn,
  output xlat_ent_t        ent_o,
  output logic             match_o,
  output logic             hole_o
);
  xlat_ent_t ent_q;
  logic      tag_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= IS_BOOT ? BOOT_ENT : '0;
    else if (wr_sel) ent_q <= wr_ent;
  end

  assign tag_hit = ent_q.valid && size_ok(ent_q.size) && tag_eq(ent_q, lk_vpn);
  assign hole_o  = in_hole(ent_q, lk_vpn);
  assign match_o = tag_hit && !hole_o;
  assign ent_o   = ent_q;

  // R8: written contents are present one cycle later
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (ent_q == $past(wr_ent)));

  // R4: a 4 KB entry never reports a window
  p_small_no_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_q.size == SZ_4K) |-> !hole_o);
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits,
  output logic          any_o,
  output logic          multi_o,
  output logic [IW-1:0] sel_o
);
  logic [IW:0] cnt;

  always_comb begin
    sel_o = '0;
    cnt   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) sel_o = IW'(i);
    end
    for (int i = 0; i < N; i++) cnt = cnt + (IW+1)'(hits[i]);
  end

  assign any_o   = |hits;
  assign multi_o = cnt > (IW+1)'(1);
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int               ENTRIES   = 16,
  parameter logic [VPN_W-1:0] BOOT_VPN  = '1,
  parameter logic [RPN_W-1:0] BOOT_RPN  = '1,
  parameter logic [2:0]       BOOT_SIZE = SZ_4K,
  localparam int              IW        = $clog2(ENTRIES),
  localparam int              BOOT_IDX  = ENTRIES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_valid,
  input  logic             wr_excl,
  input  logic [2:0]       wr_size,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [RPN_W-1:0] wr_rpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_multi,
  output logic [IW-1:0]    rsp_idx,
  output logic [RPN_W-1:0] rsp_rpn
);
  localparam xlat_ent_t BOOT_ENT = '{valid: 1'b1, excl: 1'b0, size: BOOT_SIZE,
                                     vpn: BOOT_VPN, rpn: BOOT_RPN};

  xlat_ent_t          wr_ent;
  xlat_ent_t          ent_arr [ENTRIES];
  logic [ENTRIES-1:0] hits;
  logic [ENTRIES-1:0] holes;
  logic               any_hit;
  logic               multi_hit;
  logic [IW-1:0]      sel;

  assign wr_ent = '{valid: wr_valid, excl: wr_excl, size: wr_size,
                    vpn: wr_vpn, rpn: wr_rpn};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_entry #(
      .IS_BOOT (g == BOOT_IDX),
      .BOOT_ENT(BOOT_ENT)
    ) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (wr_en && (wr_idx == IW'(g))),
      .wr_ent (wr_ent),
      .lk_vpn (lk_vpn),
      .ent_o  (ent_arr[g]),
      .match_o(hits[g]),
      .hole_o (holes[g])
    );
  end

  xlat_pick #(.N(ENTRIES), .IW(IW)) u_pick (
    .hits   (hits),
    .any_o  (any_hit),
    .multi_o(multi_hit),
    .sel_o  (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_idx   <= '0;
      rsp_rpn   <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && any_hit;
      rsp_multi <= lk_req && multi_hit;
      rsp_idx   <= (lk_req && any_hit) ? sel : '0;
      rsp_rpn   <= (lk_req && any_hit) ? rpn_out(ent_arr[sel], lk_vpn) : '0;
    end
  end

  // R7: a response only follows a request
  p_rsp_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_req));

  // R7: no hit without a response
  p_hit_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R6: multi-hit implies hit
  p_multi_has_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);

  // R6: the chosen entry hits and no lower one does
  p_sel_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hits[sel] && ((hits & ((ENTRIES'(1) << sel) - ENTRIES'(1))) == '0)));

  // R3: an entry reporting a window hit never matches
  p_hole_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && any_hit) |-> !holes[sel]);

  // R9: a miss returns zeros
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_rpn == '0 && rsp_idx == '0));
endmodule

// File: tb/xlat_cam_tb.sv
`timescale 1ns/100ps
module xlat_cam_tb;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [51:0] lk_vpn = '0;
  logic        wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic        wr_valid = 1'b0;
  logic        wr_excl = 1'b0;
  logic [2:0]  wr_size = '0;
  logic [51:0] wr_vpn = '0;
  logic [39:0] wr_rpn = '0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic [IW-1:0] rsp_idx;
  logic [39:0] rsp_rpn;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  xlat_cam u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_excl(wr_excl),
    .wr_size(wr_size), .wr_vpn(wr_vpn), .wr_rpn(wr_rpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
    .rsp_idx(rsp_idx), .rsp_rpn(rsp_rpn)
  );

  // {vpn, hit, multi, idx, rpn}
  localparam int NV = 15;
  localparam logic [97:0] VEC [NV] = '{
    {52'h12300, 1'b0, 1'b0, 4'd0, 40'h0},
    {52'h1230F, 1'b0, 1'b0, 4'd0, 40'h0},
    {52'h12310, 1'b1, 1'b0, 4'd0, 40'hAB10},
    {52'h123FF, 1'b1, 1'b0, 4'd0, 40'hABFF},
    {52'h12302, 1'b1, 1'b0, 4'd1, 40'h55502},
    {52'h12305, 1'b1, 1'b0, 4'd2, 40'h55505},
    {52'h12306, 1'b0, 1'b0, 4'd0, 40'h0},
    {52'h4000A, 1'b1, 1'b0, 4'd3, 40'h7770A},
    {52'h40010, 1'b0, 1'b0, 4'd0, 40'h0},
    {52'h3ABC,  1'b1, 1'b0, 4'd4, 40'h9ABC},
    {52'h12ABCD,1'b1, 1'b0, 4'd5, 40'hEABCD},
    {52'h22222, 1'b0, 1'b0, 4'd0, 40'h0},
    {52'h33333, 1'b1, 1'b1, 4'd7, 40'h903},
    {52'h33334, 1'b1, 1'b0, 4'd7, 40'h904},
    {52'hF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd15, 40'hFF_FFFF_FFFF}
  };
  localparam string VTAG [NV] = '{"R3", "R3", "R5", "R5", "R5", "R4", "R5",
                                  "R1", "R1", "R10", "R10", "R2", "R6", "R6", "R9"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic v, input logic x, input logic [2:0] s,
                    input logic [51:0] vpn, input logic [39:0] rpn);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = v; wr_excl = x;
    wr_size = s; wr_vpn = vpn; wr_rpn = rpn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [51:0] vpn, input logic hit,
                      input logic multi, input logic [3:0] idx, input logic [39:0] rpn);
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = vpn;
    @(negedge clk);
    lk_req = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'(1'b1));
    chk({req, " hit"},   64'(rsp_hit),   64'(hit));
    chk({req, " multi"}, 64'(rsp_multi), 64'(multi));
    chk({req, " idx"},   64'(rsp_idx),   64'(idx));
    chk({req, " rpn"},   64'(rsp_rpn),   64'(rpn));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state, boot entry live, others empty
    chk("R9 idle valid", 64'(rsp_valid), 64'(0));
    chk("R9 idle hit", 64'(rsp_hit), 64'(0));
    look("R9", 52'hF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd15, 40'hFF_FFFF_FFFF);
    look("R9", 52'h12310, 1'b0, 1'b0, 4'd0, 40'h0);
    @(negedge clk);
    chk("R7 no req", 64'(rsp_valid), 64'(0));

    wr(0, 1'b1, 1'b1, 3'b101, 52'h1230F, 40'hAB00);  // 1 MB, 64 KB window
    wr(1, 1'b1, 1'b0, 3'b001, 52'h12302, 40'h55502);
    wr(2, 1'b1, 1'b1, 3'b001, 52'h12305, 40'h55505); // R4: X on 4 KB
    wr(3, 1'b1, 1'b0, 3'b011, 52'h40000, 40'h77700);
    wr(4, 1'b1, 1'b0, 3'b111, 52'h3000,  40'h9000);
    wr(5, 1'b1, 1'b0, 3'b110, 52'h100000, 40'hC0000);
    wr(6, 1'b1, 1'b0, 3'b000, 52'h22222, 40'h1);    // R2: illegal size
    wr(7, 1'b1, 1'b0, 3'b011, 52'h33330, 40'h900);
    wr(8, 1'b1, 1'b0, 3'b001, 52'h33333, 40'h800);

    for (int i = 0; i < NV; i++)
      look(VTAG[i], VEC[i][97:46], VEC[i][45], VEC[i][44], VEC[i][43:40], VEC[i][39:0]);

    // R8: write and lookup of the same mapping in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_valid = 1'b1; wr_excl = 1'b0;
    wr_size = 3'b001; wr_vpn = 52'h77777; wr_rpn = 40'h123;
    lk_req = 1'b1; lk_vpn = 52'h77777;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    chk("R8 same-cycle miss", 64'(rsp_hit), 64'(0));
    look("R8", 52'h77777, 1'b1, 1'b0, 4'd9, 40'h123);
    wr(9, 1'b0, 1'b0, 3'b001, 52'h77777, 40'h123);
    look("R2", 52'h77777, 1'b0, 1'b0, 4'd0, 40'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule